// File: doc/BRIEF.md
# Load/Store Instruction Decoder with Address Generator

This block accepts one 32-bit load/store instruction word in the legacy fixed-width format, together with the current value of the base register and the value of the offset register, qualified by a valid strobe. It sorts the word into one of three transfer families: plain word/byte transfers, the extra halfword/signed/doubleword transfers, and exclusive accesses. It then works out what the access is: direction, size, sign extension, whether it runs with user privilege, and whether the offset comes from the instruction or from the register.

The same cycle's arithmetic forms the memory address and the new base value, and it decides whether the base is written back. Pre-indexed and post-indexed addressing are both covered, with the offset added or subtracted. Instruction bit 22 means something different in each family. In the plain family it picks byte or word. In the extra family it picks immediate or register offset. In the exclusive family it sets the size together with bit 21. The decoder resolves that meaning before any other field is read.

Every result is registered and appears one clock after the strobe. A word that fits none of the supported patterns comes back flagged as undefined, and all of its access outputs are zero. Register-file reads, condition evaluation, shifted-register offsets and the memory port all belong to neighbouring blocks.

Top module: `lsx_decode_agu`

## Requirements
- R1: All outputs are registered: `out_valid` equals `in_valid` of the previous cycle, every other output is zero in a cycle where `out_valid` is 0, and a synchronous active-high `rst` clears every output to zero.
- R2: When instr[27:26] is 01 (plain family), `out_load` equals instr[20]. `out_size` is byte (0) when instr[22] is 1 and word (2) when it is 0. `out_reg_off` equals instr[25]. The immediate offset is instr[11:0], zero-extended. The size codes are 0 byte, 1 halfword, 2 word, 3 doubleword.
- R3: A plain-family word with instr[25]=1 and instr[11:4] not zero asks for a shifted register offset and is reported as undefined.
- R4: When instr[27:25] is 000 and instr[7:4] is 1011, the access is an unsigned halfword and `out_load` equals instr[20].
- R5: When instr[27:25] is 000 and instr[7:4] is 1101, the access is a signed-byte load if instr[20] is 1 and a doubleword load if it is 0. When instr[7:4] is 1111, the access is a signed-halfword load if instr[20] is 1 and a doubleword store if it is 0. `out_signed` is only ever 1 on a load.
- R6: In the extra family, instr[22]=1 selects the immediate {instr[11:8], instr[3:0]} and instr[22]=0 selects the offset register (`out_reg_off`=1).
- R7: instr[23]=1 adds the offset to the base and instr[23]=0 subtracts it, modulo 2^32.
- R8: Pre-indexed (instr[24]=1) in the plain and extra families: `out_addr` is base ± offset, and `out_wb_en` equals instr[21].
- R9: Post-indexed (instr[24]=0) in the plain and extra families: `out_addr` is the unmodified base, `out_wb_en` is 1, `out_wb_val` is base ± offset, and `out_unpriv` equals instr[21].
- R10: A word with instr[27:23]=00011 and instr[11:4]=0xF9 is exclusive. `out_load` equals instr[20]. instr[22:21] sets the size: 00 word, 10 byte, 11 halfword, 01 doubleword. `out_addr` is the base, no writeback takes place, and the offset source is immediate.
- R11: Any other word sets `out_undef`, and load, size, sign, unprivileged, offset-source, address, writeback value and writeback enable all stay zero.
- R12: `out_wb_val` is zero whenever `out_wb_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are present |
| instr | input | 32 | Load/store instruction word |
| base_val | input | ADDR_W | Current base register value |
| offs_val | input | ADDR_W | Current offset register value |
| out_valid | output | 1 | Registered result is present |
| out_undef | output | 1 | Word matched no supported pattern |
| out_load | output | 1 | 1 load, 0 store |
| out_size | output | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| out_signed | output | 1 | Loaded value is sign-extended |
| out_unpriv | output | 1 | Access runs with user privilege |
| out_reg_off | output | 1 | Offset came from the offset register |
| out_addr | output | ADDR_W | Memory access address |
| out_wb_val | output | ADDR_W | New base value |
| out_wb_en | output | 1 | Write `out_wb_val` back to the base |

## Verification
The bench reuses the same instruction word with bit 22 toggled in each family. A decoder that reads bit 22 one way for every family would report halfword transfers as byte-sized, or pick the wrong offset source. Post-indexed words with bit 21 set are checked for the user-privilege flag with a single writeback; a design that treated them as pre-indexed writeback would emit the offset address instead of the base. Exclusive words are checked to bypass both the offset and the writeback, and a word that asks for a shifted offset must come out undefined rather than silently unshifted. A subtraction below zero checks the address wraparound.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    localparam int INSTR_W = 32;
    localparam int IMM_W   = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DUAL = 2'd3
    } lsx_size_e;

    typedef enum logic [1:0] {
        GRP_NONE   = 2'd0,
        GRP_PLAIN  = 2'd1,
        GRP_EXTRA  = 2'd2,
        GRP_EXCL   = 2'd3
    } lsx_grp_e;

    typedef struct packed {
        lsx_grp_e         grp;
        logic             undef;
        logic             load;
        lsx_size_e        size;
        logic             sext;
        logic             unpriv;
        logic             use_reg;
        logic [IMM_W-1:0] imm;
        logic             pre;
        logic             add;
        logic             wback;
    } lsx_dec_t;

endpackage

// File: rtl/lsx_classify.sv
module lsx_classify
    import lsx_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output lsx_dec_t           dec
);

    logic fam_plain;
    logic fam_shift_req;
    logic fam_excl;
    logic fam_extra;
    logic unused_fields;

    // Condition field and register numbers belong to other blocks.
    assign unused_fields = ^{instr[31:28], instr[19:12]};

    assign fam_plain     = (instr[27:26] == 2'b01);
    assign fam_shift_req = instr[25] && (instr[11:4] != 8'h00);
    assign fam_excl      = (instr[27:23] == 5'b00011) && (instr[11:4] == 8'hF9);
    assign fam_extra     = (instr[27:25] == 3'b000) && instr[7] && instr[4]
                           && (instr[6:5] != 2'b00);

    always_comb begin
        dec = '0;
        dec.undef = 1'b1;
        dec.grp   = GRP_NONE;

        if (fam_plain && !fam_shift_req) begin
            dec.grp     = GRP_PLAIN;
            dec.undef   = 1'b0;
            dec.load    = instr[20];
            dec.size    = instr[22] ? SZ_BYTE : SZ_WORD;
            dec.use_reg = instr[25];
            dec.imm     = instr[11:0];
            dec.pre     = instr[24];
            dec.add     = instr[23];
            dec.wback   = !instr[24] || instr[21];
            dec.unpriv  = !instr[24] && instr[21];
        end else if (fam_excl) begin
            dec.grp     = GRP_EXCL;
            dec.undef   = 1'b0;
            dec.load    = instr[20];
            dec.pre     = 1'b1;
            dec.add     = 1'b1;
            dec.wback   = 1'b0;
            dec.use_reg = 1'b0;
            dec.imm     = '0;
            unique case (instr[22:21])
                2'b00:   dec.size = SZ_WORD;
                2'b10:   dec.size = SZ_BYTE;
                2'b11:   dec.size = SZ_HALF;
                default: dec.size = SZ_DUAL;
            endcase
        end else if (fam_extra) begin
            dec.grp     = GRP_EXTRA;
            dec.undef   = 1'b0;
            dec.use_reg = !instr[22];
            dec.imm     = {4'b0000, instr[11:8], instr[3:0]};
            dec.pre     = instr[24];
            dec.add     = instr[23];
            dec.wback   = !instr[24] || instr[21];
            dec.unpriv  = !instr[24] && instr[21];
            unique case (instr[6:5])
                2'b01: begin
                    dec.load = instr[20];
                    dec.size = SZ_HALF;
                    dec.sext = 1'b0;
                end
                2'b10: begin
                    dec.load = 1'b1;
                    dec.size = instr[20] ? SZ_BYTE : SZ_DUAL;
                    dec.sext = instr[20];
                end
                default: begin
                    dec.load = instr[20];
                    dec.size = instr[20] ? SZ_HALF : SZ_DUAL;
                    dec.sext = instr[20];
                end
            endcase
        end
    end

endmodule

// File: rtl/lsx_agu.sv
module lsx_agu
    import lsx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  lsx_dec_t          dec,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] offs_val,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] wb_val,
    output logic              wb_en
);

    localparam int PAD_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] moved;
    logic              unused_dec;

    assign unused_dec = ^{dec.grp, dec.undef, dec.load, dec.size, dec.sext, dec.unpriv};

    always_comb begin
        offset = dec.use_reg ? offs_val : {{PAD_W{1'b0}}, dec.imm};
        moved  = dec.add ? (base_val + offset) : (base_val - offset);
        addr   = dec.pre ? moved : base_val;
        wb_en  = dec.wback;
        wb_val = dec.wback ? moved : '0;
    end

endmodule

// File: rtl/lsx_decode_agu.sv
module lsx_decode_agu
    import lsx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic [ADDR_W-1:0]   offs_val,
    output logic                out_valid,
    output logic                out_undef,
    output logic                out_load,
    output logic [1:0]          out_size,
    output logic                out_signed,
    output logic                out_unpriv,
    output logic                out_reg_off,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [ADDR_W-1:0]   out_wb_val,
    output logic                out_wb_en
);

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic              load;
        lsx_size_e         size;
        logic              sext;
        logic              unpriv;
        logic              use_reg;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wbv;
        logic              wben;
    } res_t;

    lsx_dec_t          dec_w;
    logic [ADDR_W-1:0] agu_addr;
    logic [ADDR_W-1:0] agu_wbv;
    logic              agu_wben;
    res_t              res_d;
    res_t              res_q;

    lsx_classify u_classify (
        .instr (instr),
        .dec   (dec_w)
    );

    lsx_agu #(.ADDR_W(ADDR_W)) u_agu (
        .dec      (dec_w),
        .base_val (base_val),
        .offs_val (offs_val),
        .addr     (agu_addr),
        .wb_val   (agu_wbv),
        .wb_en    (agu_wben)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            res_d.undef = dec_w.undef;
            if (!dec_w.undef) begin
                res_d.load    = dec_w.load;
                res_d.size    = dec_w.size;
                res_d.sext    = dec_w.sext;
                res_d.unpriv  = dec_w.unpriv;
                res_d.use_reg = dec_w.use_reg;
                res_d.addr    = agu_addr;
                res_d.wbv     = agu_wbv;
                res_d.wben    = agu_wben;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_undef   = res_q.undef;
    assign out_load    = res_q.load;
    assign out_size    = res_q.size;
    assign out_signed  = res_q.sext;
    assign out_unpriv  = res_q.unpriv;
    assign out_reg_off = res_q.use_reg;
    assign out_addr    = res_q.addr;
    assign out_wb_val  = res_q.wbv;
    assign out_wb_en   = res_q.wben;

endmodule

// File: rtl/lsx_decode_agu_chk.sv
module lsx_decode_agu_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic [ADDR_W-1:0] base_val,
    input logic              out_valid,
    input logic              out_undef,
    input logic              out_load,
    input logic [1:0]        out_size,
    input logic              out_signed,
    input logic              out_unpriv,
    input logic [ADDR_W-1:0] out_addr,
    input logic [ADDR_W-1:0] out_wb_val,
    input logic              out_wb_en
);

    logic excl_in;
    logic post_plain_in;

    assign excl_in       = in_valid && (instr[27:23] == 5'b00011) && (instr[11:4] == 8'hF9);
    assign post_plain_in = in_valid && (instr[27:26] == 2'b01) && !instr[24]
                           && !(instr[25] && (instr[11:4] != 8'h00));

    p_valid_rise_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_wb_en && out_addr == '0));

    p_undef_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (!out_load && out_size == 2'd0 && !out_signed && !out_unpriv
                       && !out_wb_en && out_addr == '0 && out_wb_val == '0));

    p_sext_load_r5: assert property (@(posedge clk) disable iff (rst)
        out_signed |-> out_load);

    p_unpriv_wb_r9: assert property (@(posedge clk) disable iff (rst)
        out_unpriv |-> out_wb_en);

    p_post_base_r9: assert property (@(posedge clk) disable iff (rst)
        post_plain_in |=> (out_addr == $past(base_val) && out_wb_en));

    p_excl_base_r10: assert property (@(posedge clk) disable iff (rst)
        excl_in |=> (out_addr == $past(base_val) && !out_wb_en && !out_undef));

    p_wb_zero_r12: assert property (@(posedge clk) disable iff (rst)
        !out_wb_en |-> (out_wb_val == '0));

endmodule

bind lsx_decode_agu lsx_decode_agu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .base_val   (base_val),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .out_load   (out_load),
    .out_size   (out_size),
    .out_signed (out_signed),
    .out_unpriv (out_unpriv),
    .out_addr   (out_addr),
    .out_wb_val (out_wb_val),
    .out_wb_en  (out_wb_en)
);

// File: tb/tb_lsx_decode_agu.sv
`timescale 1ns/1ps
module tb_lsx_decode_agu;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [31:0] base_val;
    logic [31:0] offs_val;
    logic        out_valid, out_undef, out_load, out_signed, out_unpriv, out_reg_off, out_wb_en;
    logic [1:0]  out_size;
    logic [31:0] out_addr, out_wb_val;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lsx_decode_agu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .base_val(base_val), .offs_val(offs_val),
        .out_valid(out_valid), .out_undef(out_undef), .out_load(out_load),
        .out_size(out_size), .out_signed(out_signed), .out_unpriv(out_unpriv),
        .out_reg_off(out_reg_off), .out_addr(out_addr), .out_wb_val(out_wb_val),
        .out_wb_en(out_wb_en)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] base;
        logic [31:0] offs;
        logic        undef;
        logic        load;
        logic [1:0]  size;
        logic        sext;
        logic        unpriv;
        logic        regoff;
        logic [31:0] addr;
        logic [31:0] wbv;
        logic        wben;
        logic [3:0]  tag;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        // R2 word load, immediate, pre-indexed, no writeback
        '{32'hE5901010, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h1010, 32'h0, 1'b0, 4'd2},
        // R2 R7 R8 byte store, register offset subtracted, pre-indexed with writeback
        '{32'hE7601000, 32'h1000, 32'h20, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 32'hFE0, 32'hFE0, 1'b1, 4'd2},
        // R9 post-indexed with W set: unprivileged word load
        '{32'hE4B01004, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 32'h1000, 32'h1004, 1'b1, 4'd9},
        // R9 post-indexed byte load, subtract
        '{32'hE4501008, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'hFF8, 1'b1, 4'd9},
        // R3 shifted register offset requested
        '{32'hE7901100, 32'h1000, 32'h20, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd3},
        // R4 R6 halfword load, split immediate 0x25
        '{32'hE1D012B5, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h1025, 32'h0, 1'b0, 4'd4},
        // R6 R8 halfword store, register offset, pre-indexed writeback, subtract
        '{32'hE12010B0, 32'h1000, 32'h20, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 32'hFE0, 32'hFE0, 1'b1, 4'd6},
        // R5 signed byte load, register, post-indexed
        '{32'hE09010D0, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 32'h1000, 32'h1020, 1'b1, 4'd5},
        // R5 doubleword load, immediate 8
        '{32'hE1C010D8, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 32'h1008, 32'h0, 1'b0, 4'd5},
        // R5 signed halfword load, immediate 4
        '{32'hE1D010F4, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 32'h1004, 32'h0, 1'b0, 4'd5},
        // R8 doubleword store, pre-indexed writeback, immediate 0x3C
        '{32'hE1E013FC, 32'h1000, 32'h20, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 32'h103C, 32'h103C, 1'b1, 4'd8},
        // R6 R9 unprivileged halfword store, post-indexed, subtract 2
        '{32'hE06010B2, 32'h1000, 32'h20, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 32'h1000, 32'hFFE, 1'b1, 4'd6},
        // R10 exclusive word load
        '{32'hE1901F9F, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 1'b0, 4'd10},
        // R10 exclusive byte store
        '{32'hE1C01F92, 32'h1000, 32'h20, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 1'b0, 4'd10},
        // R10 exclusive halfword load
        '{32'hE1F01F9F, 32'h1000, 32'h20, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 1'b0, 4'd10},
        // R10 exclusive doubleword store
        '{32'hE1A04F92, 32'h1000, 32'h20, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 1'b0, 4'd10},
        // R11 data-processing word
        '{32'hE0810002, 32'h1000, 32'h20, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd11},
        // R11 coprocessor word
        '{32'hEE000000, 32'h1000, 32'h20, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd11},
        // R7 subtraction wraps below zero
        '{32'hE5101020, 32'h10,   32'h20, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 32'hFFFFFFF0, 32'h0, 1'b0, 4'd7}
    };

    function automatic logic [71:0] pack_out();
        return {out_valid, out_undef, out_load, out_size, out_signed, out_unpriv,
                out_reg_off, out_addr, out_wb_val, out_wb_en};
    endfunction

    task automatic check(input string req, input logic [71:0] got, input logic [71:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] i, input logic [31:0] b, input logic [31:0] o);
        @(negedge clk);
        in_valid = v;
        instr    = i;
        base_val = b;
        offs_val = o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        instr = '0;
        base_val = '0;
        offs_val = '0;
        repeat (3) @(negedge clk);

        // R1 reset holds every output at zero even with a strobe present
        drive(1'b1, 32'hE5901010, 32'h1000, 32'h20);
        @(negedge clk);
        check("R1 reset", pack_out(), 72'h0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 idle", pack_out(), 72'h0);

        // Table walk: each vector is applied for one cycle and checked one cycle later
        for (int k = 0; k < NVEC; k++) begin
            drive(1'b1, VECS[k].ins, VECS[k].base, VECS[k].offs);
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VECS[k].tag, k), pack_out(),
                  {1'b1, VECS[k].undef, VECS[k].load, VECS[k].size, VECS[k].sext,
                   VECS[k].unpriv, VECS[k].regoff, VECS[k].addr, VECS[k].wbv, VECS[k].wben});
        end

        // R1 latency: result not visible before the edge, visible after
        drive(1'b0, 32'h0, 32'h0, 32'h0);
        drive(1'b1, 32'hE1D012B5, 32'h2000, 32'h0);
        #1;
        check("R1 before edge", {71'h0, out_valid}, 72'h0);
        @(negedge clk);
        check("R1 after edge", pack_out(),
              {1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h2025, 32'h0, 1'b0});

        // R1 R12 strobe dropped: payload clears on the next edge
        in_valid = 1'b0;
        instr = 32'hE4B01004;
        @(negedge clk);
        check("R1 R12 strobe low", pack_out(), 72'h0);

        // R6 bit 22 cleared in the extra family turns the immediate into register
        drive(1'b1, 32'hE19012B5, 32'h2000, 32'h100);
        @(negedge clk);
        check("R6 bit22 clear", pack_out(),
              {1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h2100, 32'h0, 1'b0});

        // R1 synchronous reset in the middle of a stream
        drive(1'b1, 32'hE4B01004, 32'h3000, 32'h0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset", pack_out(), 72'h0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule